// File: doc/BRIEF.md
# Load/Store Immediate Address Unit

This unit sits between instruction decode and the memory pipeline of a 64-bit core. It takes a 32-bit load/store instruction word, the current value of the base register that the word names, and the program counter. One cycle later it presents a decoded request: the effective address, the access size in bytes, the direction, which register file supplies or receives the data, and the width of a general-register destination. It also presents the updated base value for writeback and the next program counter. Encodings that are not supported, or that would give an undefined result, raise an illegal flag. A misaligned stack-pointer base raises a fault flag. Either flag blocks the request.

Two single-register immediate forms are fully decoded. The scaled unsigned-offset form adds its offset before the access. The post-indexed form accesses memory at the base and then writes back the base plus a signed offset. The three register-pair forms are only classified and reported. The unit moves no data and holds no register file.

The input side uses a valid/ready handshake, and so does the registered output stage.

Top module: `ldst_imm_agu`

## Requirements
- R1: An input is captured when `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R2: The unsigned-offset form is recognised by bits [29:27]=111 and [25:24]=01. Its effective address is the base plus imm12 (bits [21:10]), zero-extended and shifted left by the scale. It has no base writeback.
- R3: The post-indexed form is recognised by [29:27]=111, [25:24]=00, [21]=0 and [11:10]=01. Its address is the unmodified base. Its writeback value is the base plus imm9 (bits [20:12]), sign-extended, and the writeback enable is set.
- R4: Bits [31:30] (size), [26] (vector file) and [23:22] (opc) drive the access:
  - The scale is {opc[1], size} for the vector file and size alone for the general file.
  - The byte count is 1 shifted left by the scale.
  - opc[0]=1 means load and opc[0]=0 means store.
- R5: For the general file, only size 00, 10 or 11 with opc 00 or 01 is accepted. Every other general-file combination raises the illegal flag.
- R6: For the vector file, opc 00 or 01 is accepted with any size, and opc 10 or 11 is accepted only with size 00 (a 16-byte access). Every other combination, and any scale above 4, is illegal.
- R7: A general-file post-indexed access is illegal when the base index (bits [9:5]) equals the data index (bits [4:0]) and is not 31.
- R8: A legal single-register access whose base index is 31 raises the fault flag when base[3:0] is not zero.
- R9: `out_dst64` is high exactly when a general-file access has size 11. A general-file load zero-extends its data to 64 bits in that case and to 32 bits otherwise.
- R10: When [29:27]=101, bits [25:23] classify a pair form: 011 gives pre-indexed (`out_pair`=1), 001 gives post-indexed (2) and 010 gives signed offset (3). Bit 26 is reported as the file and bit 22 as load. No memory request is issued.
- R11: `out_next_pc` is `in_pc`+4 for every decoded instruction with neither flag set. Otherwise it is `in_pc`.
- R12: A word that matches none of the recognised patterns (including a pair with any other [25:23] value) raises the illegal flag.
- R13: When the illegal flag or the fault flag is set, `out_req` and `out_wb_en` are both low. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands valid |
| in_ready | output | 1 | Unit can capture an input |
| in_insn | input | 32 | Instruction word |
| in_base | input | AW | Current value of the base register |
| in_pc | input | AW | Program counter of the instruction |
| out_valid | output | 1 | Registered result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_req | output | 1 | Memory request is to be issued |
| out_addr | output | AW | Effective address |
| out_bytes | output | 5 | Access size in bytes |
| out_load | output | 1 | 1 = load, 0 = store |
| out_vec | output | 1 | Vector/FP register file selected |
| out_dst64 | output | 1 | General destination is 64 bits wide |
| out_wb_en | output | 1 | Base register writeback enable |
| out_wb_val | output | AW | Base writeback value |
| out_pair | output | 2 | Pair form class: 0 none, 1 pre, 2 post, 3 signed offset |
| out_illegal | output | 1 | Unsupported or unpredictable encoding |
| out_fault | output | 1 | Stack-pointer alignment fault |
| out_next_pc | output | AW | Next program counter |

## Verification
Two functions can land on the same instruction: a post-indexed writeback and a stack-pointer alignment fault. The bench triggers this with a post-indexed word whose base index is 31 and whose base value is misaligned. The result must show the fault set, with both the writeback enable and the request low. A second collision pairs the overlap rule with index 31. A post-indexed word with base and data both set to 31 and a 16-byte-aligned base must be accepted, because the overlap rule exempts index 31 and the alignment check passes. Back-pressure is checked by holding `out_ready` low while a second word waits at the input. The first result must stay unchanged until it is released.

// File: rtl/ldst_imm_agu.sv
module ldst_imm_agu #(
  parameter int AW = 64,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_insn,
  input  logic [AW-1:0] in_base,
  input  logic [AW-1:0] in_pc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_req,
  output logic [AW-1:0] out_addr,
  output logic [4:0]    out_bytes,
  output logic          out_load,
  output logic          out_vec,
  output logic          out_dst64,
  output logic          out_wb_en,
  output logic [AW-1:0] out_wb_val,
  output logic [1:0]    out_pair,
  output logic          out_illegal,
  output logic          out_fault,
  output logic [AW-1:0] out_next_pc
);
  localparam logic [4:0] SP_IDX = 5'd31;

  logic [1:0] sz, opc;
  logic       vf;
  logic [4:0] rn, rt;
  assign sz  = in_insn[31:30];
  assign vf  = in_insn[26];
  assign opc = in_insn[23:22];
  assign rn  = in_insn[9:5];
  assign rt  = in_insn[4:0];

  logic is_uoff, is_post, single, is_pair;
  logic [1:0] pair_kind;
  assign is_uoff = in_insn[29:27] == 3'b111 && in_insn[25:24] == 2'b01;
  assign is_post = in_insn[29:27] == 3'b111 && in_insn[25:24] == 2'b00
                   && !in_insn[21] && in_insn[11:10] == 2'b01;
  assign single  = is_uoff || is_post;

  always_comb begin
    pair_kind = 2'd0;
    if (in_insn[29:27] == 3'b101) begin
      case (in_insn[25:23])
        3'b011:  pair_kind = 2'd1;
        3'b001:  pair_kind = 2'd2;
        3'b010:  pair_kind = 2'd3;
        default: pair_kind = 2'd0;
      endcase
    end
  end
  assign is_pair = pair_kind != 2'd0;

  logic [2:0] scale;
  logic gpr_ok, vec_ok, unpred, bad, sp_fault, ok;
  assign scale  = vf ? {opc[1], sz} : {1'b0, sz};
  assign gpr_ok = !vf && !opc[1] && sz != 2'b01;
  assign vec_ok = vf && (!opc[1] || sz == 2'b00) && scale <= 3'd4;
  assign unpred = !vf && is_post && rn == rt && rn != SP_IDX;
  assign bad    = !(single || is_pair) ||
                  (single && (!(gpr_ok || vec_ok) || unpred));
  assign sp_fault = single && !bad && rn == SP_IDX &&
                    in_base[SP_ALIGN_BITS-1:0] != '0;
  assign ok     = !bad && !sp_fault;

  logic [AW-1:0] uoff, soff, addr_c;
  assign uoff   = {{(AW-12){1'b0}}, in_insn[21:10]} << scale;
  assign soff   = {{(AW-9){in_insn[20]}}, in_insn[20:12]};
  assign addr_c = is_uoff ? in_base + uoff : in_base;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_req     <= 1'b0;
      out_addr    <= '0;
      out_bytes   <= '0;
      out_load    <= 1'b0;
      out_vec     <= 1'b0;
      out_dst64   <= 1'b0;
      out_wb_en   <= 1'b0;
      out_wb_val  <= '0;
      out_pair    <= '0;
      out_illegal <= 1'b0;
      out_fault   <= 1'b0;
      out_next_pc <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_req     <= single && ok;
        out_addr    <= addr_c;
        out_bytes   <= 5'd1 << scale;
        out_load    <= is_pair ? in_insn[22] : opc[0];
        out_vec     <= vf;
        out_dst64   <= !vf && sz == 2'b11;
        out_wb_en   <= is_post && ok;
        out_wb_val  <= in_base + soff;
        out_pair    <= pair_kind;
        out_illegal <= bad;
        out_fault   <= sp_fault;
        out_next_pc <= ok ? in_pc + AW'(4) : in_pc;
      end
    end
  end

  assert_hold_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
    $stable(out_wb_val) && $stable(out_next_pc) && $stable(out_req));

  assert_block_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_no_req_on_error_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_illegal || out_fault) |-> !out_req && !out_wb_en);

  assert_flags_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_illegal && out_fault));

  assert_size_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_req |-> $onehot(out_bytes));

  assert_pair_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pair != 2'd0 |-> !out_req && !out_wb_en && !out_illegal);
endmodule

// File: tb/test_ldst_imm_agu.sv
module test_ldst_imm_agu;
  localparam int AW = 64;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready;
  logic [31:0] in_insn = '0;
  logic [AW-1:0] in_base = '0, in_pc = '0;
  logic out_valid, out_req, out_load, out_vec, out_dst64, out_wb_en, out_illegal, out_fault;
  logic [AW-1:0] out_addr, out_wb_val, out_next_pc;
  logic [4:0] out_bytes;
  logic [1:0] out_pair;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ldst_imm_agu #(.AW(AW)) i_ldst_imm_agu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_base(in_base), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_req(out_req),
    .out_addr(out_addr), .out_bytes(out_bytes), .out_load(out_load),
    .out_vec(out_vec), .out_dst64(out_dst64), .out_wb_en(out_wb_en),
    .out_wb_val(out_wb_val), .out_pair(out_pair), .out_illegal(out_illegal),
    .out_fault(out_fault), .out_next_pc(out_next_pc));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_uoff(input logic [1:0] s, input logic v,
      input logic [1:0] o, input logic [11:0] imm, input logic [4:0] n, input logic [4:0] t);
    return {s, 3'b111, v, 2'b01, o, imm, n, t};
  endfunction
  function automatic logic [31:0] enc_post(input logic [1:0] s, input logic v,
      input logic [1:0] o, input logic [8:0] imm, input logic [4:0] n, input logic [4:0] t);
    return {s, 3'b111, v, 2'b00, o, 1'b0, imm, 2'b01, n, t};
  endfunction
  function automatic logic [31:0] enc_pair(input logic v, input logic [2:0] m, input logic l);
    return {2'b10, 3'b101, v, m, l, 7'd3, 5'd4, 5'd2, 5'd1};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] b, input logic [63:0] pc);
    @(negedge clk);
    in_insn = w; in_base = b; in_pc = pc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [63:0] addr, input logic [4:0] nb,
      input logic ld, input logic wb, input logic [63:0] pc);
    chk({tag, " valid"}, out_valid, 1);
    chk({tag, " req"}, out_req, 1);
    chk({tag, " addr"}, out_addr, addr);
    chk({tag, " bytes"}, out_bytes, nb);
    chk({tag, " load"}, out_load, ld);
    chk({tag, " wb_en"}, out_wb_en, wb);
    chk({tag, " flags"}, {out_illegal, out_fault}, 0);
    chk({tag, " next_pc R11"}, out_next_pc, pc + 4);
  endtask

  task automatic expect_bad(input string tag, input logic ill, input logic flt, input logic [63:0] pc);
    chk({tag, " illegal"}, out_illegal, ill);
    chk({tag, " fault"}, out_fault, flt);
    chk({tag, " req off R13"}, out_req, 0);
    chk({tag, " wb off R13"}, out_wb_en, 0);
    chk({tag, " pc held R11"}, out_next_pc, pc);
  endtask

  task automatic t_reset;
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset in_ready", in_ready, 1);
  endtask

  task automatic t_uoff;
    issue(enc_uoff(2'b11, 1'b0, 2'b01, 12'd3, 5'd2, 5'd5), 64'h1000, 64'h400);
    expect_ok("R2 gpr64 load uoff", 64'h1018, 5'd8, 1, 0, 64'h400);
    chk("R9 dst64 size11", out_dst64, 1);
    chk("R4 gpr file", out_vec, 0);
    issue(enc_uoff(2'b00, 1'b1, 2'b11, 12'd2, 5'd2, 5'd5), 64'h3000, 64'h800);
    expect_ok("R6 vec128 load uoff", 64'h3020, 5'd16, 1, 0, 64'h800);
    chk("R4 vec file", out_vec, 1);
    issue(enc_uoff(2'b10, 1'b0, 2'b01, 12'd1, 5'd2, 5'd5), 64'h100, 64'h10);
    expect_ok("R9 gpr32 load", 64'h104, 5'd4, 1, 0, 64'h10);
    chk("R9 dst64 size10", out_dst64, 0);
  endtask

  task automatic t_post;
    issue(enc_post(2'b00, 1'b0, 2'b00, 9'h1FC, 5'd3, 5'd4), 64'h2000, 64'h20);
    expect_ok("R3 byte store post", 64'h2000, 5'd1, 0, 1, 64'h20);
    chk("R3 wb negative", out_wb_val, 64'h1FFC);
    issue(enc_post(2'b01, 1'b1, 2'b00, 9'd5, 5'd3, 5'd3), 64'h2000, 64'h30);
    expect_ok("R4 vec16 store post", 64'h2000, 5'd2, 0, 1, 64'h30);
    chk("R3 wb positive", out_wb_val, 64'h2005);
  endtask

  task automatic t_illegal;
    issue(enc_uoff(2'b01, 1'b0, 2'b01, 12'd0, 5'd1, 5'd2), 64'h0, 64'h40);
    expect_bad("R5 gpr size01", 1, 0, 64'h40);
    issue(enc_uoff(2'b11, 1'b0, 2'b10, 12'd0, 5'd1, 5'd2), 64'h0, 64'h40);
    expect_bad("R5 gpr opc10", 1, 0, 64'h40);
    issue(enc_uoff(2'b01, 1'b1, 2'b10, 12'd0, 5'd1, 5'd2), 64'h0, 64'h44);
    expect_bad("R6 vec size01 opc10", 1, 0, 64'h44);
    issue(enc_post(2'b11, 1'b0, 2'b01, 9'd8, 5'd7, 5'd7), 64'h0, 64'h48);
    expect_bad("R7 overlap", 1, 0, 64'h48);
    issue(32'h0000_0000, 64'h0, 64'h4C);
    expect_bad("R12 unknown word", 1, 0, 64'h4C);
    issue(enc_pair(1'b0, 3'b000, 1'b1), 64'h0, 64'h50);
    expect_bad("R12 pair mode000", 1, 0, 64'h50);
  endtask

  task automatic t_sp;
    issue(enc_post(2'b11, 1'b0, 2'b01, 9'd16, 5'd31, 5'd31), 64'h7000, 64'h60);
    expect_ok("R7 rn=rt=31 exempt", 64'h7000, 5'd8, 1, 1, 64'h60);
    issue(enc_post(2'b11, 1'b0, 2'b00, 9'd16, 5'd31, 5'd2), 64'h7008, 64'h64);
    expect_bad("R8 sp misaligned post", 0, 1, 64'h64);
    issue(enc_uoff(2'b11, 1'b0, 2'b01, 12'd0, 5'd30, 5'd2), 64'h7008, 64'h68);
    chk("R8 non-sp base no fault", out_fault, 0);
  endtask

  task automatic t_pair;
    issue(enc_pair(1'b0, 3'b011, 1'b1), 64'h0, 64'h70);
    chk("R10 pre kind", out_pair, 1);
    chk("R10 pre load", out_load, 1);
    chk("R10 pre no req", out_req, 0);
    chk("R11 pair pc", out_next_pc, 64'h74);
    issue(enc_pair(1'b1, 3'b001, 1'b0), 64'h0, 64'h70);
    chk("R10 post kind", out_pair, 2);
    chk("R10 post vec", out_vec, 1);
    chk("R10 post store", out_load, 0);
    issue(enc_pair(1'b0, 3'b010, 1'b1), 64'h0, 64'h70);
    chk("R10 signed kind", out_pair, 3);
    chk("R10 not illegal", out_illegal, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk); out_ready = 1'b0;
    issue(enc_uoff(2'b11, 1'b0, 2'b01, 12'd1, 5'd2, 5'd5), 64'h100, 64'h90);
    @(negedge clk);
    in_insn = enc_uoff(2'b11, 1'b0, 2'b01, 12'd2, 5'd2, 5'd5);
    in_base = 64'h200; in_valid = 1'b1;
    chk("R1 in_ready low", in_ready, 0);
    @(negedge clk); @(negedge clk);
    chk("R1 held addr", out_addr, 64'h108);
    chk("R1 held valid", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 second captured", out_addr, 64'h210);
    @(negedge clk);
    chk("R1 drained", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_uoff();
    t_post();
    t_illegal();
    t_sp();
    t_pair();
    t_backpressure();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule